// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block is the command front end of a parallel NOR flash that carries a protected boot block. Each bus write cycle presents an address, an 8-bit byte and a write strobe. The controller decodes these into two-cycle program and erase sequences and starts a simplified program/erase engine. The engine is a countdown timer that acts on a small word-addressable array. The same controller keeps a status register, selects what reads return (array contents, status or identifier), supports suspending and resuming an erase, and refuses to modify the boot block unless an unlock input is high.

The array is scaled down to 2^ADDR_W words (512 by default) and is split into seven erase blocks in fixed proportions. Counting outward from the boot end of the address space, they are a 16-unit boot block, two 8-unit parameter blocks, one 96-unit main block and three 128-unit main blocks. The `boot_top` input selects whether the boot block sits at the lowest or the highest addresses. Reads are combinational from `addr` under the current read mode.

Top module: `bbf_cmd_ctrl`

## Requirements
- R1: Program needs 40h followed by a data cycle, and erase needs 20h followed by D0h. A single write of any other byte (data, D0h, and so on) in read-array mode starts nothing and leaves the array unchanged.
- R2: While an erase is running and not suspended, every command write except B0h is ignored. Reads return the status byte, which is 00h while the engine runs.
- R3: B0h during an erase pauses it, and status then reads C0h (bit 7 ready, bit 6 suspended). While suspended, FFh gives array reads of the untouched data, and D0h resumes the erase, which then completes.
- R4: The status byte is {ready, suspended, erase error, program error, voltage error, 000}. Bits 2..0 always read 0. The error bits stay set until a 50h command. The value after reset is 80h.
- R5: A program or erase confirmed while `vpp_ok` is low sets the voltage error bit together with the operation's error bit (98h for program, A8h for erase) and leaves the array unchanged. While the voltage error bit is set, no program or erase starts, even with `vpp_ok` high.
- R6: A program stores old AND new at the addressed word. Only an erase returns bits to 1.
- R7: An erase sets every word of the addressed block to FFh and leaves the words just outside that block unchanged. Bottom placement: boot 0-15, parameters 16-23 and 24-31, main 32-127, 128-255, 256-383, 384-511. Top placement mirrors this: boot 496-511, parameters 488-495 and 480-487, main 384-479, 256-383, 128-255, 0-127.
- R8: With `boot_unlock` low, a program aimed at the boot block sets the program error bit (status 90h) and an erase sets the erase error bit (status A0h). The array is not changed.
- R9: After a program or erase completes, reads keep returning status (80h) until FFh is written.
- R10: An erase setup followed by any byte other than D0h sets both error bits 4 and 5 (status B0h) and starts no erase.
- R11: The engine keeps the ready bit low for exactly PROG_CYC cycles after a program data cycle and ERASE_CYC cycles after an erase confirm.
- R12: After 90h, a read at an even address returns MFR_ID and a read at an odd address returns DEV_ID.
- R13: Asserting `rst_n` aborts any running operation without modifying the array and restores read-array mode with status 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| boot_top | input | 1 | 1 places the boot block at the top of the address space |
| boot_unlock | input | 1 | 1 permits program and erase of the boot block |
| vpp_ok | input | 1 | Programming voltage is within range |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 8 | Command or program data |
| rdata | output | 8 | Read data under the current read mode |

## Verification
The assertions assume that `wr_en` is a clean one-cycle strobe with `addr` and `wdata` valid in the same cycle. They also assume that `boot_top` and `boot_unlock` do not change between an operation's confirm and its completion, because the protection and block checks use their values at those points. The bench always drives inputs at the falling edge, holds the configuration inputs constant while an operation runs, and changes `boot_top` only across a reset. Reads are issued with `wr_en` low, so the controller's state cannot move during a compare.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STAT  = 8'h50;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_STATUS = 2'd1, RM_ID = 2'd2} rmode_t;
  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_PROG = 2'd1, SQ_ERASE = 2'd2} seq_t;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_t;

  // Block index counted from the boot end: 0 boot, 1..2 parameter, 3..6 main.
  function automatic logic [2:0] blk_index(input int unsigned a, input int unsigned aw,
                                           input logic top);
    int unsigned d;
    int unsigned m;
    d = 32'd1 << aw;
    m = top ? (d - 1 - a) : a;
    if (m < d / 32)                return 3'd0;
    else if (m < d / 32 + d / 64)  return 3'd1;
    else if (m < d / 16)           return 3'd2;
    else if (m < d / 4)            return 3'd3;
    else if (m < d / 2)            return 3'd4;
    else if (m < (3 * d) / 4)      return 3'd5;
    else                           return 3'd6;
  endfunction

endpackage

// File: rtl/bbf_blk_decode.sv
module bbf_blk_decode #(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_top,
  output logic [2:0]        blk,
  output logic              is_boot
);
  import bbf_pkg::*;

  always_comb begin
    blk     = blk_index(32'(addr), ADDR_W, boot_top);
    is_boot = (blk == 3'd0);
  end
endmodule

// File: rtl/bbf_engine.sv
module bbf_engine #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          hold,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                      cnt_d = load_val;
    else if (cnt_q != '0 && !hold) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1)) && !hold;
endmodule

// File: rtl/bbf_array.sv
module bbf_array #(
  parameter int ADDR_W = 9,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              boot_top,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [ADDR_W-1:0] tg_addr,
  output logic [DW-1:0]     tg_data,
  input  logic              prog_en,
  input  logic [DW-1:0]     prog_data,
  input  logic              erase_en,
  input  logic [2:0]        erase_blk
);
  import bbf_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] words [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam int unsigned WI = w;
    logic [DW-1:0] q;
    logic          hit_blk;
    assign hit_blk = (blk_index(WI, ADDR_W, boot_top) == erase_blk);
    always_ff @(posedge clk) begin
      if (prog_en && tg_addr == ADDR_W'(WI)) q <= q & prog_data;
      else if (erase_en && hit_blk)          q <= '1;
    end
    assign words[w] = q;
  end

  assign rd_data = words[rd_addr];
  assign tg_data = words[tg_addr];
endmodule

// File: rtl/bbf_cmd_ctrl.sv
module bbf_cmd_ctrl #(
  parameter int         ADDR_W    = 9,
  parameter int         PROG_CYC  = 4,
  parameter int         ERASE_CYC = 12,
  parameter logic [7:0] MFR_ID    = 8'h4D,
  parameter logic [7:0] DEV_ID    = 8'hB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_top,
  input  logic              boot_unlock,
  input  logic              vpp_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  import bbf_pkg::*;
  localparam int DW   = 8;
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rmode_t            mode_q, mode_d;
  seq_t              seq_q, seq_d;
  op_t               op_q, op_d;
  logic              susp_q, susp_d;
  logic [2:0]        err_q, err_d;          // [0] voltage, [1] program, [2] erase
  logic [ADDR_W-1:0] tgt_a_q, tgt_a_d;
  logic [DW-1:0]     tgt_w_q, tgt_w_d;

  logic          busy, done, eng_load;
  logic [CW-1:0] eng_val;
  logic [2:0]    bus_blk, tgt_blk;
  logic          bus_boot, tgt_boot;
  logic [DW-1:0] arr_rd, tg_word;
  logic          prog_en, erase_en;
  logic [7:0]    status;

  bbf_blk_decode #(.ADDR_W(ADDR_W)) u_bus_dec (
    .addr(addr), .boot_top(boot_top), .blk(bus_blk), .is_boot(bus_boot));
  bbf_blk_decode #(.ADDR_W(ADDR_W)) u_tgt_dec (
    .addr(tgt_a_q), .boot_top(boot_top), .blk(tgt_blk), .is_boot(tgt_boot));

  bbf_engine #(.CW(CW)) u_eng (
    .clk(clk), .rst_ni(rst_ni), .load(eng_load), .load_val(eng_val),
    .hold(susp_q), .busy(busy), .done(done));

  assign prog_en  = done && (op_q == OP_PROG);
  assign erase_en = done && (op_q == OP_ERASE);

  bbf_array #(.ADDR_W(ADDR_W), .DW(DW)) u_arr (
    .clk(clk), .boot_top(boot_top), .rd_addr(addr), .rd_data(arr_rd),
    .tg_addr(tgt_a_q), .tg_data(tg_word), .prog_en(prog_en),
    .prog_data(tgt_w_q), .erase_en(erase_en), .erase_blk(tgt_blk));

  assign status = {(!busy || susp_q), susp_q, err_q, 3'b000};

  always_comb begin
    mode_d   = mode_q;
    seq_d    = seq_q;
    op_d     = op_q;
    susp_d   = susp_q;
    err_d    = err_q;
    tgt_a_d  = tgt_a_q;
    tgt_w_d  = tgt_w_q;
    eng_load = 1'b0;
    eng_val  = CW'(PROG_CYC);
    if (busy) begin
      if (!susp_q) begin
        if (wr_en && op_q == OP_ERASE && wdata == CMD_SUSPEND) begin
          susp_d = 1'b1;
          mode_d = RM_STATUS;
        end
      end else if (wr_en) begin
        case (wdata)
          CMD_READ_ARRAY:  mode_d = RM_ARRAY;
          CMD_READ_STATUS: mode_d = RM_STATUS;
          CMD_READ_ID:     mode_d = RM_ID;
          CMD_CLEAR_STAT:  err_d  = '0;
          CMD_CONFIRM: begin
            susp_d = 1'b0;
            mode_d = RM_STATUS;
          end
          default: ;
        endcase
      end
    end else if (wr_en) begin
      case (seq_q)
        SQ_PROG: begin
          seq_d  = SQ_IDLE;
          mode_d = RM_STATUS;
          if (err_q[0] || !vpp_ok)          err_d = err_q | 3'b011;
          else if (bus_boot && !boot_unlock) err_d = err_q | 3'b010;
          else begin
            eng_load = 1'b1;
            eng_val  = CW'(PROG_CYC);
            op_d     = OP_PROG;
            tgt_a_d  = addr;
            tgt_w_d  = wdata;
          end
        end
        SQ_ERASE: begin
          seq_d  = SQ_IDLE;
          mode_d = RM_STATUS;
          if (wdata != CMD_CONFIRM)          err_d = err_q | 3'b110;
          else if (err_q[0] || !vpp_ok)      err_d = err_q | 3'b101;
          else if (bus_boot && !boot_unlock) err_d = err_q | 3'b100;
          else begin
            eng_load = 1'b1;
            eng_val  = CW'(ERASE_CYC);
            op_d     = OP_ERASE;
            tgt_a_d  = addr;
          end
        end
        default: begin
          case (wdata)
            CMD_READ_ARRAY:  mode_d = RM_ARRAY;
            CMD_READ_STATUS: mode_d = RM_STATUS;
            CMD_READ_ID:     mode_d = RM_ID;
            CMD_CLEAR_STAT:  err_d  = '0;
            CMD_PROG_SETUP: begin
              seq_d  = SQ_PROG;
              mode_d = RM_STATUS;
            end
            CMD_ERASE_SETUP: begin
              seq_d  = SQ_ERASE;
              mode_d = RM_STATUS;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= RM_ARRAY;
      seq_q   <= SQ_IDLE;
      op_q    <= OP_PROG;
      susp_q  <= 1'b0;
      err_q   <= '0;
      tgt_a_q <= '0;
      tgt_w_q <= '0;
    end else begin
      mode_q  <= mode_d;
      seq_q   <= seq_d;
      op_q    <= op_d;
      susp_q  <= susp_d;
      err_q   <= err_d;
      tgt_a_q <= tgt_a_d;
      tgt_w_q <= tgt_w_d;
    end
  end

  always_comb begin
    case (mode_q)
      RM_STATUS: rdata = status;
      RM_ID:     rdata = addr[0] ? DEV_ID : MFR_ID;
      default:   rdata = arr_rd;
    endcase
  end
endmodule

// File: rtl/bbf_checker.sv
module bbf_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          wr_en,
  input logic [7:0]    wdata,
  input logic          busy,
  input logic          susp,
  input logic          op_erase,
  input logic [1:0]    mode,
  input logic [7:0]    status,
  input logic [1:0]    seq,
  input logic          bus_boot,
  input logic          boot_unlock,
  input logic          done_prog,
  input logic [DW-1:0] tg_word,
  input logic [DW-1:0] tgt_word_q
);
  // R1: a single write from idle never starts the engine
  p_single_write_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && seq == 2'd0 && wr_en) |=> !busy);

  // R2: commands other than suspend are ignored while the engine runs
  p_busy_ignore_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !susp && wr_en && wdata != 8'hB0) |=> (!susp && $stable(mode)));

  // R3: suspend during an erase reports ready and suspended
  p_suspend_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && op_erase && !susp && wr_en && wdata == 8'hB0) |=> (status[7:6] == 2'b11));

  // R4: reserved status bits stay zero
  p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    status[2:0] == 3'b000);

  // R5: a standing voltage error blocks the program data cycle
  p_vpp_lock_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && status[3] && seq == 2'd1 && wr_en) |=> !busy);

  // R6: a completed program leaves old AND new in the target word
  p_prog_and_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    done_prog |=> (tg_word == $past(tg_word & tgt_word_q)));

  // R8: a locked boot block never starts an operation
  p_boot_lock_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && seq != 2'd0 && wr_en && bus_boot && !boot_unlock) |=> !busy);
endmodule

bind bbf_cmd_ctrl bbf_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wdata(wdata), .busy(busy),
  .susp(susp_q), .op_erase(op_q == bbf_pkg::OP_ERASE), .mode(mode_q),
  .status(status), .seq(seq_q), .bus_boot(bus_boot), .boot_unlock(boot_unlock),
  .done_prog(prog_en), .tg_word(tg_word), .tgt_word_q(tgt_w_q));

// File: tb/tb_bbf_cmd_ctrl.sv
module tb_bbf_cmd_ctrl;
  localparam int         AW    = 9;
  localparam int         PCYC  = 4;
  localparam int         ECYC  = 12;
  localparam logic [7:0] MFR   = 8'h4D;
  localparam logic [7:0] DEV   = 8'hB7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          boot_top, boot_unlock, vpp_ok, wr_en;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;

  always #4 clk = ~clk;   // 125 MHz

  bbf_cmd_ctrl #(.ADDR_W(AW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC),
                 .MFR_ID(MFR), .DEV_ID(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .boot_top(boot_top), .boot_unlock(boot_unlock),
    .vpp_ok(vpp_ok), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t      sb_q[$];
  int         n_chk = 0, n_fail = 0;
  logic [7:0] m [512];

  // scoreboard monitor: compares reads queued by the driver
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() != 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic chk(input int a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = AW'(a);
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_val(input int got, input int e, input string tag);
    n_chk++;
    if (got != e) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, e);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (rdata[7] !== 1'b1 && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic prog(input int a, input logic [7:0] d, input logic ok);
    int n;
    wr(0, 8'h40); wr(a, d); wait_ready(n);
    if (ok) m[a] = m[a] & d;
  endtask

  task automatic erase(input int a, input int lo, input int hi, input logic ok);
    int n;
    wr(0, 8'h20); wr(a, 8'hD0); wait_ready(n);
    if (ok) for (int i = lo; i <= hi; i++) m[i] = 8'hFF;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    wr_en = 0; addr = '0; wdata = '0;
    boot_top = 0; boot_unlock = 1; vpp_ok = 1;
    do_reset();

    // R4 / R13 reset state
    wr(0, 8'h70); chk(0, 8'h80, "R4 reset status");
    // R12 identifier
    wr(0, 8'h90);
    chk(0, MFR, "R12 even id"); chk(1, DEV, "R12 odd id"); chk(2, MFR, "R12 even id 2");

    // erase everything; first erase times the engine (R11)
    wr(0, 8'h20); wr(0, 8'hD0); wait_ready(n);
    chk_val(n, ECYC, "R11 erase duration");
    for (int i = 0; i < 16; i++) m[i] = 8'hFF;
    erase(16, 16, 23, 1); erase(24, 24, 31, 1); erase(32, 32, 127, 1);
    erase(128, 128, 255, 1); erase(256, 256, 383, 1); erase(384, 384, 511, 1);

    // R11 program duration, R9 status held, R6 AND
    wr(0, 8'h40); wr(50, 8'hA5); wait_ready(n);
    chk_val(n, PCYC, "R11 program duration");
    m[50] = 8'hA5;
    chk(50, 8'h80, "R9 status after program");
    wr(0, 8'hFF); chk(50, m[50], "R6 first program");
    prog(50, 8'h3C, 1); wr(0, 8'hFF); chk(50, 8'h24, "R6 AND of two programs");

    // R1 stray writes
    wr(60, 8'h00); wr(60, 8'hD0); chk(60, 8'hFF, "R1 stray write ignored");

    // R10 bad confirm, R4 sticky and clear
    wr(0, 8'h20); wr(0, 8'h77); chk(0, 8'hB0, "R10 sequence error");
    prog(61, 8'h0F, 1); chk(0, 8'hB0, "R4 error bits sticky");
    wr(0, 8'h50); chk(0, 8'h80, "R4 clear status");
    wr(0, 8'hFF); chk(61, m[61], "R6 program after clear");

    // R7 bottom map boundaries
    prog(31, 8'h00, 1); prog(32, 8'h00, 1); prog(127, 8'h00, 1); prog(128, 8'h00, 1);
    erase(100, 32, 127, 1); wr(0, 8'hFF);
    chk(31, m[31], "R7 below main96"); chk(32, 8'hFF, "R7 main96 low");
    chk(127, 8'hFF, "R7 main96 high"); chk(128, m[128], "R7 above main96");
    prog(15, 8'h00, 1); prog(16, 8'h00, 1); prog(23, 8'h00, 1); prog(24, 8'h00, 1);
    erase(20, 16, 23, 1); wr(0, 8'hFF);
    chk(15, m[15], "R7 boot edge"); chk(16, 8'hFF, "R7 param low");
    chk(23, 8'hFF, "R7 param high"); chk(24, m[24], "R7 second param");

    // R5 voltage error
    vpp_ok = 0; prog(70, 8'h00, 0); chk(0, 8'h98, "R5 program vpp error");
    vpp_ok = 1; prog(70, 8'h00, 0); chk(0, 8'h98, "R5 blocked while set");
    wr(0, 8'hFF); chk(70, m[70], "R5 array unchanged");
    wr(0, 8'h50); prog(70, 8'h00, 1); wr(0, 8'hFF); chk(70, m[70], "R5 works after clear");
    vpp_ok = 0; erase(70, 32, 127, 0); chk(0, 8'hA8, "R5 erase vpp error");
    vpp_ok = 1; wr(0, 8'h50);

    // R8 boot lock
    boot_unlock = 0;
    prog(3, 8'h00, 0); chk(0, 8'h90, "R8 boot program locked");
    wr(0, 8'hFF); chk(3, m[3], "R8 boot word unchanged");
    wr(0, 8'h50); erase(3, 0, 15, 0); chk(0, 8'hA0, "R8 boot erase locked");
    wr(0, 8'hFF); chk(15, m[15], "R8 boot block not erased");
    wr(0, 8'h50); boot_unlock = 1;
    prog(3, 8'h00, 1); wr(0, 8'hFF); chk(3, 8'h00, "R8 unlocked program");

    // R2 / R3 suspend and resume
    prog(130, 8'h00, 1);
    wr(0, 8'h20); wr(200, 8'hD0);
    wr(0, 8'hFF); chk(130, 8'h00, "R2 reads give busy status");
    wr(130, 8'h40);
    wr(0, 8'hB0); chk(0, 8'hC0, "R3 suspended status");
    wr(0, 8'hFF); chk(130, 8'h00, "R3 array read while suspended");
    wr(0, 8'hD0); wait_ready(n);
    for (int i = 128; i <= 255; i++) m[i] = 8'hFF;
    chk(0, 8'h80, "R3 resumed erase finished");
    wr(0, 8'hFF); chk(130, 8'hFF, "R3 block erased"); chk(127, m[127], "R3 neighbour kept");

    // R13 reset aborts an erase
    prog(400, 8'h00, 1);
    wr(0, 8'h20); wr(450, 8'hD0);
    repeat (3) @(negedge clk);
    do_reset();
    chk(400, 8'h00, "R13 erase aborted, array mode");
    wr(0, 8'h70); chk(0, 8'h80, "R13 status after reset");

    // top placement
    boot_top = 1; do_reset(); boot_unlock = 0;
    prog(500, 8'h00, 0); chk(0, 8'h90, "R8 top boot locked");
    wr(0, 8'h50); prog(5, 8'h00, 1); chk(0, 8'h80, "R7 low end is main in top map");
    prog(479, 8'h00, 1); prog(480, 8'h00, 1); prog(487, 8'h00, 1); prog(488, 8'h00, 1);
    erase(484, 480, 487, 1); wr(0, 8'hFF);
    chk(479, m[479], "R7 top main96 edge"); chk(480, 8'hFF, "R7 top param low");
    chk(487, 8'hFF, "R7 top param high"); chk(488, m[488], "R7 top first param");
    chk(500, m[500], "R8 top boot word unchanged"); chk(5, m[5], "R7 top low main");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule